// File: doc/BRIEF.md
# DMA Descriptor Write Port

This block is the processor-facing entry point of a DMA engine. Software writes a transfer descriptor one 32-bit word at a time into staging registers, with byte enables, so that narrow fields can be updated alone. Writing the control word with its commit bit set turns the staged fields into one packed descriptor and loads it, whole, into a small descriptor queue. The read and write masters downstream take descriptors from the head of that queue through a valid/ready handshake.

A build-time parameter picks one of two layouts. The compact layout has four words: read address, write address, length and control. The extended layout has eight words and adds a sequence tag, per-side burst counts, per-side strides and the upper halves of both addresses. The control word is the last word in both layouts, so the committing offset depends on the layout. Staged values stay in place after a commit. Software can change one field and commit again.

Top module: `dma_desc_port`

## Requirements
- R1: After reset, `descValid`, `descFull` and `descOverflow` are 0 and every staging register is 0. A first commit that writes only the control word yields a descriptor whose other fields are all zero.
- R2: With `EXTENDED=0`, word indices 0..3 (byte offsets 0x0..0xC) hold the read address, write address, length and control word. Writes to indices 4..7 are ignored. In `descOut`, the upper 32 bits of both addresses and the bits 223:160 are zero.
- R3: With `EXTENDED=1`, eight words are used. Index 0 is the read address bits 31:0 and index 5 is bits 63:32. Index 1 is the write address bits 31:0 and index 6 is bits 63:32. Index 2 is the length. Index 3 holds the sequence tag in bits 15:0, the read burst in bits 23:16 and the write burst in bits 31:24. Index 4 holds the read stride in bits 15:0 and the write stride in bits 31:16. Index 7 is the control word. The layout of `descOut` is: control in 255:224, write stride in 223:208, read stride in 207:192, write burst in 191:184, read burst in 183:176, sequence in 175:160, length in 159:128, write address in 127:64 and read address in 63:0.
- R4: A write changes only the byte lanes whose `wrByteEn` bit is set. Lane k is `wrData[8k+7:8k]`.
- R5: A descriptor is queued only by a write to the control word index (3 compact, 7 extended) that has `wrByteEn[3]=1` and `wrData[31]=1`. A control write with bit 31 clear, or with lane 3 disabled, updates the staging register and queues nothing. A write with bit 31 set to any other index also queues nothing.
- R6: The queued descriptor includes the bytes of the committing write itself.
- R7: The queue is first in, first out. `descValid` is high whenever it holds an entry, and `descOut` shows the oldest entry. That entry is removed on a clock edge where `descValid` and `descReady` are both high. The head stays stable while it is not accepted.
- R8: `descFull` is high when `FIFO_DEPTH` entries are held. A commit while `descFull` is high is dropped, even if the head is taken in the same cycle. The drop sets `descOverflow`, which stays high until reset.
- R9: Staging registers keep their values across a commit. A later commit repeats every field that was not rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrWord | input | 3 | Word index (byte offset divided by four) |
| wrData | input | 32 | Write data |
| wrByteEn | input | 4 | Byte lane enables |
| descFull | output | 1 | Queue holds FIFO_DEPTH entries |
| descOverflow | output | 1 | Sticky: a commit was dropped |
| descValid | output | 1 | Queue head is valid |
| descReady | input | 1 | Consumer takes the head |
| descOut | output | 256 | Packed head descriptor |

## Verification
The assertions take for granted that a consumer holds `descReady` as a plain level and that writes arrive as single-cycle strobes, with the word index in range for the layout. Out-of-range indices in compact mode are still tolerated. They also assume that `wrByteEn` is meaningful only while `wrEn` is high. The stimulus drives every input once per cycle on the falling edge. It runs a compact and an extended instance from the same write stream. Each write is therefore legal for both layouts, even when it is ignored by one of them. A behavioural queue model is compared with both instances on every cycle.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  localparam int WORD_W   = 32;
  localparam int LANES    = WORD_W / 8;
  localparam int MAX_WRDS = 8;
  localparam int IDX_W    = $clog2(MAX_WRDS);
  localparam int COMMIT_B = 31;

  // Packed descriptor as seen by downstream masters (MSB first).
  typedef struct packed {
    logic [31:0] control;
    logic [15:0] wrStride;
    logic [15:0] rdStride;
    logic [7:0]  wrBurst;
    logic [7:0]  rdBurst;
    logic [15:0] seqTag;
    logic [31:0] xferLen;
    logic [63:0] wrAddr;
    logic [63:0] rdAddr;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  // Strobes from the decode/control side to the staging datapath.
  typedef struct packed {
    logic [MAX_WRDS-1:0] wordSel;
    logic [LANES-1:0]    laneEn;
    logic                push;
  } stage_stb_t;

endpackage

// File: rtl/desc_ctrl.sv
module desc_ctrl
  import dma_desc_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrWord,
  input  logic             wrCommitBit,
  input  logic [LANES-1:0] wrByteEn,
  input  logic             fifoFull,
  output stage_stb_t       stb,
  output logic             overflow
);

  localparam int WORDS    = EXTENDED ? 8 : 4;
  localparam int CTRL_IDX = WORDS - 1;

  logic inRange;
  logic commitReq;
  logic overflowQ;

  assign inRange   = (32'(wrWord) < WORDS);
  assign commitReq = wrEn && inRange && (32'(wrWord) == CTRL_IDX)
                     && wrByteEn[LANES-1] && wrCommitBit;

  always_comb begin
    stb = '0;
    for (int w = 0; w < MAX_WRDS; w++) begin
      stb.wordSel[w] = wrEn && inRange && (32'(wrWord) == w);
    end
    stb.laneEn = wrEn ? wrByteEn : '0;
    stb.push   = commitReq && !fifoFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowQ <= 1'b0;
    end else if (commitReq && fifoFull) begin
      overflowQ <= 1'b1;
    end
  end

  assign overflow = overflowQ;

  // R8: once set, the drop flag stays until reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ);

  // R5: a queued descriptor always comes from a control-word write with lane 3
  a_r5_push_from_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (stb.wordSel[CTRL_IDX] && stb.laneEn[LANES-1]));

  // R8: a write-side strobe never reaches a full queue
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !stb.push);

endmodule

// File: rtl/desc_datapath.sv
module desc_datapath
  import dma_desc_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_stb_t        stb,
  input  logic [WORD_W-1:0] wrData,
  output desc_t             nextDesc
);

  localparam int WORDS = EXTENDED ? 8 : 4;

  logic [WORD_W-1:0] stageQ [WORDS];
  logic [WORD_W-1:0] stageD [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign stageD[w][8*b +: 8] = (stb.wordSel[w] && stb.laneEn[b])
                                   ? wrData[8*b +: 8] : stageQ[w][8*b +: 8];

      // R4: a lane not addressed by the strobe keeps its byte
      a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rstN)
        !(stb.wordSel[w] && stb.laneEn[b]) |=> $stable(stageQ[w][8*b +: 8]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[w] <= '0;
      end else begin
        stageQ[w] <= stageD[w];
      end
    end
  end

  // Pushed entry is built from the merged (same-cycle) word values.
  if (EXTENDED) begin : g_ext_map
    always_comb begin
      nextDesc          = '0;
      nextDesc.rdAddr   = {stageD[5], stageD[0]};
      nextDesc.wrAddr   = {stageD[6], stageD[1]};
      nextDesc.xferLen  = stageD[2];
      nextDesc.seqTag   = stageD[3][15:0];
      nextDesc.rdBurst  = stageD[3][23:16];
      nextDesc.wrBurst  = stageD[3][31:24];
      nextDesc.rdStride = stageD[4][15:0];
      nextDesc.wrStride = stageD[4][31:16];
      nextDesc.control  = stageD[7];
    end
  end else begin : g_cmp_map
    always_comb begin
      nextDesc         = '0;
      nextDesc.rdAddr  = {32'h0, stageD[0]};
      nextDesc.wrAddr  = {32'h0, stageD[1]};
      nextDesc.xferLen = stageD[2];
      nextDesc.control = stageD[3];
    end
  end

endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popReady,
  output logic             headValid,
  output logic [WIDTH-1:0] headData,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign headValid = (count != '0);
  assign full      = (count == CNT_FULL);
  assign pop       = headValid && popReady;
  assign headData  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (pop) begin
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
      if (push && !pop) begin
        count <= count + 1'b1;
      end else if (pop && !push) begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wrPtr] <= pushData;
    end
  end

  // R8: occupancy never passes the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL);

  // R7: an entry not taken stays at the head
  a_r7_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !popReady) |=> (headValid && $stable(headData)));

  // R7: a taken head with no new entry lowers occupancy by one
  a_r7_pop_drains: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/dma_desc_port.sv
module dma_desc_port
  import dma_desc_pkg::*;
#(
  parameter bit EXTENDED   = 1'b1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrWord,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrByteEn,
  output logic              descFull,
  output logic              descOverflow,
  output logic              descValid,
  input  logic              descReady,
  output logic [DESC_W-1:0] descOut
);

  stage_stb_t stb;
  desc_t      nextDesc;

  desc_ctrl #(.EXTENDED(EXTENDED)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrWord     (wrWord),
    .wrCommitBit(wrData[COMMIT_B]),
    .wrByteEn   (wrByteEn),
    .fifoFull   (descFull),
    .stb        (stb),
    .overflow   (descOverflow)
  );

  desc_datapath #(.EXTENDED(EXTENDED)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .nextDesc(nextDesc)
  );

  desc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DESC_W)) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (stb.push),
    .pushData (nextDesc),
    .popReady (descReady),
    .headValid(descValid),
    .headData (descOut),
    .full     (descFull)
  );

endmodule

// File: tb/test_dma_desc_port.sv
`timescale 1ns/1ps
module test_dma_desc_port;

  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrWord = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrByteEn = '0;
  logic        descReady = 1'b0;

  logic        fullE, ovE, validE, fullC, ovC, validC;
  logic [255:0] outE, outC;

  dma_desc_port #(.EXTENDED(1'b1), .FIFO_DEPTH(DEPTH)) i_dma_desc_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord), .wrData(wrData),
    .wrByteEn(wrByteEn), .descFull(fullE), .descOverflow(ovE),
    .descValid(validE), .descReady(descReady), .descOut(outE));

  dma_desc_port #(.EXTENDED(1'b0), .FIFO_DEPTH(DEPTH)) i_dma_desc_port_c (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord), .wrData(wrData),
    .wrByteEn(wrByteEn), .descFull(fullC), .descOverflow(ovC),
    .descValid(validC), .descReady(descReady), .descOut(outC));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model: index 0 compact, index 1 extended.
  logic [31:0]  mw [2][8];
  logic [255:0] qC[$];
  logic [255:0] qE[$];
  bit           movC, movE;

  function automatic logic [255:0] packM(int m);
    logic [255:0] r = '0;
    if (m == 1) begin
      r[63:0]    = {mw[1][5], mw[1][0]};
      r[127:64]  = {mw[1][6], mw[1][1]};
      r[159:128] = mw[1][2];
      r[175:160] = mw[1][3][15:0];
      r[183:176] = mw[1][3][23:16];
      r[191:184] = mw[1][3][31:24];
      r[207:192] = mw[1][4][15:0];
      r[223:208] = mw[1][4][31:16];
      r[255:224] = mw[1][7];
    end else begin
      r[31:0]    = mw[0][0];
      r[95:64]   = mw[0][1];
      r[159:128] = mw[0][2];
      r[255:224] = mw[0][3];
    end
    return r;
  endfunction

  task automatic modelCycle();
    if (!rstN) begin
      for (int m = 0; m < 2; m++) for (int w = 0; w < 8; w++) mw[m][w] = '0;
      qC.delete(); qE.delete(); movC = 0; movE = 0;
    end else begin
      for (int m = 0; m < 2; m++) begin
        int n = (m == 1) ? 8 : 4;
        int sz = (m == 1) ? qE.size() : qC.size();
        bit commit = 0;
        if (wrEn && int'(wrWord) < n) begin
          for (int b = 0; b < 4; b++)
            if (wrByteEn[b]) mw[m][wrWord][8*b +: 8] = wrData[8*b +: 8];
          commit = (int'(wrWord) == n - 1) && wrByteEn[3] && wrData[31];
        end
        if (sz > 0 && descReady) begin
          if (m == 1) void'(qE.pop_front()); else void'(qC.pop_front());
        end
        if (commit) begin
          if (sz < DEPTH) begin
            if (m == 1) qE.push_back(packM(1)); else qC.push_back(packM(0));
          end else begin
            if (m == 1) movE = 1; else movC = 1;
          end
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R7 ext valid", 256'(validE), 256'(qE.size() != 0));
    chk("R8 ext full", 256'(fullE), 256'(qE.size() == DEPTH));
    chk("R8 ext overflow", 256'(ovE), 256'(movE));
    if (qE.size() != 0) chk("R3 ext head", outE, qE[0]);
    chk("R7 cmp valid", 256'(validC), 256'(qC.size() != 0));
    chk("R8 cmp full", 256'(fullC), 256'(qC.size() == DEPTH));
    chk("R8 cmp overflow", 256'(ovC), 256'(movC));
    if (qC.size() != 0) chk("R2 cmp head", outC, qC[0]);
  endtask

  task automatic step(bit rst, bit wen, int word, logic [31:0] data,
                      logic [3:0] be, bit rdy);
    @(negedge clk);
    compareAll();
    rstN = rst; wrEn = wen; wrWord = 3'(word); wrData = data;
    wrByteEn = be; descReady = rdy;
    @(posedge clk);
    #1 modelCycle();
  endtask

  task automatic wr(int word, logic [31:0] data, logic [3:0] be);
    step(1, 1, word, data, be, 0);
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(1, 0, 0, 32'h0, 4'h0, rdy);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(0, 0, 0, 32'h0, 4'h0, 0);
    idle(1, 0);
    // R1: reset state
    chk("R1 ext valid", 256'(validE), 256'(0));
    chk("R1 ext full", 256'(fullE), 256'(0));
    chk("R1 ext overflow", 256'(ovE), 256'(0));
    chk("R1 cmp valid", 256'(validC), 256'(0));
    // R1: control-only commit exposes zeroed staging
    wr(7, 32'h8000_0000, 4'hF);
    chk("R1 ext zero staging", outE, {32'h8000_0000, 224'h0});
    idle(1, 1);

    // R3/R6: full extended programme
    wr(0, 32'h1000_0000, 4'hF);
    wr(1, 32'h2000_0000, 4'hF);
    wr(2, 32'h0000_0400, 4'hF);
    wr(3, 32'h4433_7788, 4'hF);
    wr(4, 32'h6655_2211, 4'hF);
    wr(5, 32'h0000_00AB, 4'hF);
    wr(6, 32'h0000_00CD, 4'hF);
    wr(7, 32'h8100_C301, 4'hF);
    chk("R6 ext control in pushed entry", 256'(outE[255:224]), 256'(32'h8100_C301));
    chk("R3 ext read address", 256'(outE[63:0]), 256'(64'h0000_00AB_1000_0000));

    // R4: narrow lane writes to bursts and write stride
    wr(3, 32'h00A5_0000, 4'b0100);
    wr(3, 32'h5A00_0000, 4'b1000);
    wr(4, 32'hBEEF_0000, 4'b1100);
    wr(7, 32'h8100_C301, 4'hF);
    idle(1, 1);
    chk("R4 write burst", 256'(outE[191:184]), 256'(8'h5A));
    chk("R4 read burst", 256'(outE[183:176]), 256'(8'hA5));
    chk("R4 sequence kept", 256'(outE[175:160]), 256'(16'h7788));
    chk("R4 write stride", 256'(outE[223:208]), 256'(16'hBEEF));
    chk("R4 read stride kept", 256'(outE[207:192]), 256'(16'h2211));
    chk("R9 read address kept", 256'(outE[63:0]), 256'(64'h0000_00AB_1000_0000));
    idle(2, 1);

    // R5: writes that must not queue
    wr(7, 32'h0000_00FF, 4'hF);
    chk("R5 bit31 clear no push", 256'(validE), 256'(0));
    wr(7, 32'h8000_0000, 4'b0111);
    chk("R5 lane3 off no push", 256'(validE), 256'(0));
    wr(2, 32'h8000_0000, 4'hF);
    chk("R5 non-control index no push", 256'(validE), 256'(0));

    // R2: compact layout; index 5 ignored, commit at index 3
    wr(5, 32'hFFFF_FFFF, 4'hF);
    wr(0, 32'h0000_1111, 4'hF);
    wr(1, 32'h0000_2222, 4'hF);
    wr(3, 32'h8000_00AA, 4'hF);
    chk("R2 cmp control", 256'(outC[255:224]), 256'(32'h8000_00AA));
    chk("R2 cmp upper read address zero", 256'(outC[63:32]), 256'(0));
    chk("R5 ext index3 no push", 256'(validE), 256'(0));
    idle(3, 1);

    // R8: fill the extended queue and drop one
    for (int i = 0; i < 5; i++) begin
      wr(2, 32'(i + 16), 4'hF);
      wr(7, 32'h8000_0000 | 32'(i), 4'hF);
    end
    chk("R8 full after depth commits", 256'(fullE), 256'(1));
    chk("R8 overflow on drop", 256'(ovE), 256'(1));
    // R8: commit while full with head taken is still dropped
    step(1, 1, 7, 32'h8000_0077, 4'hF, 1);
    // R7: drain with alternating ready
    for (int i = 0; i < 10; i++) idle(1, i[0]);
    chk("R8 overflow sticky", 256'(ovE), 256'(1));

    // R8: fill compact queue too
    for (int i = 0; i < 5; i++) wr(3, 32'h8000_0100 | 32'(i), 4'hF);
    chk("R8 cmp overflow", 256'(ovC), 256'(1));
    idle(8, 1);

    // R8: reset clears the flag
    step(0, 0, 0, 32'h0, 4'h0, 0);
    step(0, 0, 0, 32'h0, 4'h0, 0);
    idle(1, 0);
    chk("R8 overflow cleared by reset", 256'(ovE), 256'(0));
    idle(2, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule